// File: doc/BRIEF.md
# Data-Cache Line Refill Engine

After a data-cache miss, this block fetches one whole cache line from a memory-mapped read port. It takes a miss request that carries a byte address. It clears the line-offset bits of that address to get the line base. It then reads every 32-bit word of the line in ascending order, starting at the base. Each word goes to the line storage together with its index inside the line. When the last word has been written, the block raises a completion pulse.

Two elaboration-time parameters set the fetch strategy. One is the line size: 4, 16 or 32 bytes. The other is a burst-enable option. With bursting enabled and a line of more than one word, the line is fetched with a single burst command whose length equals the number of words in the line. Otherwise the block issues one single-word read per word, with the address stepping by 4. These single reads are pipelined, so data may return while later commands are still pending. The total cache capacity is also a parameter, checked for consistency with the line size.

Top module: `line_refill_engine`

## Requirements
- R1: During and right after a synchronous reset, `busy`, `done`, `rd_req` and `line_we` are all 0.
- R2: The first read command of a refill carries the miss address with its low log2(LINE_BYTES) bits cleared.
- R3: With bursting enabled and LINE_BYTES of 16 or 32, a refill issues exactly one command at the line base, with `rd_burstcount` equal to 4 (16-byte line) or 8 (32-byte line).
- R4: With bursting disabled, a refill issues LINE_BYTES/4 commands with `rd_burstcount` = 1, at base, base+4, base+8, … in ascending order.
- R5: A 4-byte line is always fetched with a single command of `rd_burstcount` = 1, even when bursting is enabled.
- R6: While `rd_req` is high and `rd_waitreq` is high, the block keeps `rd_req` high and holds `rd_addr` and `rd_burstcount` unchanged.
- R7: Each cycle with `rd_dvalid` high during a refill raises `line_we` in the same cycle. `line_wdata` equals `rd_data`, and `line_idx` counts 0, 1, … in arrival order.
- R8: Returned data is accepted any number of cycles after its command, including cycles in which further single-word commands are still being issued.
- R9: `busy` rises in the cycle after a miss is accepted and falls in the cycle after the last word is written. In that same cycle `done` is high for exactly one cycle.
- R10: A `miss_valid` request is ignored while `busy` is high. No extra command is issued and the refill in progress is unchanged.
- R11: LINE_BYTES must be 4, 16 or 32. CACHE_BYTES must be 0 (no cache) or a power of two from 512 to 65536. Any other value stops elaboration. Every legal line size elaborates and completes refills.
- R12: A synchronous reset in the middle of a refill returns the block to idle, drops `rd_req` and clears the beat count, so the next refill starts at index 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| miss_valid | input | 1 | Miss request strobe |
| miss_addr | input | ADDR_W | Byte address of the missing access |
| busy | output | 1 | Refill in progress |
| done | output | 1 | One-cycle pulse after the last word is written |
| rd_req | output | 1 | Read command request |
| rd_addr | output | ADDR_W | Read command byte address |
| rd_burstcount | output | $clog2(LINE_BYTES/4)+1 | Words requested by the command |
| rd_waitreq | input | 1 | Memory stalls the command this cycle |
| rd_dvalid | input | 1 | Returned read data valid |
| rd_data | input | 32 | Returned read data word |
| line_we | output | 1 | Line storage write strobe |
| line_idx | output | max(1,$clog2(LINE_BYTES/4)) | Word index within the line |
| line_wdata | output | 32 | Word written to the line storage |

## Verification
The hardest case to reach is single-word mode with returned words overlapping commands that are still stalled. That requires latency and back-pressure to vary together. The memory model draws both the stall and the return timing from a free-running LFSR, so over a series of refills data arrives before, during and after the command phase. The bench counts those overlaps. Ignored requests are provoked by holding `miss_valid` high while a refill is busy. Any stray command then shows up as an unexpected entry against the scoreboard's command queue.

// File: rtl/refill_pkg.sv
package refill_pkg;

   typedef enum logic [1:0] {
      RF_IDLE = 2'd0,
      RF_CMD  = 2'd1,
      RF_WAIT = 2'd2
   } refill_state_e;

   function automatic int index_width(input int words);
      return (words > 1) ? $clog2(words) : 1;
   endfunction

endpackage

// File: rtl/refill_cmd_gen.sv
module refill_cmd_gen #(
   parameter int ADDR_W    = 32,
   parameter int WORDS     = 8,
   parameter int IDX_W     = 3,
   parameter int BC_W      = 4,
   parameter bit USE_BURST = 1'b1
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              start,
   input  logic              active,
   input  logic [ADDR_W-1:0] base_addr,
   input  logic              rd_waitreq,
   output logic [ADDR_W-1:0] rd_addr,
   output logic [BC_W-1:0]   rd_burstcount,
   output logic              cmd_done
);

   logic [IDX_W-1:0] cmd_cnt_q;
   logic             last_cmd;
   logic             cmd_taken;

   assign cmd_taken = active && !rd_waitreq;
   assign cmd_done  = cmd_taken && last_cmd;

   generate
      if (USE_BURST) begin : g_burst
         assign rd_addr       = base_addr;
         assign rd_burstcount = BC_W'(WORDS);
         assign last_cmd      = 1'b1;
      end else begin : g_single
         assign rd_addr       = base_addr + (ADDR_W'(cmd_cnt_q) << 2);
         assign rd_burstcount = BC_W'(1);
         assign last_cmd      = (cmd_cnt_q == IDX_W'(WORDS - 1));

         // step of 4 between consecutive single reads
         assert_addr_step_R4: assert property (@(posedge clk) disable iff (rst)
            (cmd_taken && !last_cmd) |=> (rd_addr == $past(rd_addr) + ADDR_W'(4)));
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (rst || start) begin
         cmd_cnt_q <= '0;
      end else if (cmd_taken && !last_cmd) begin
         cmd_cnt_q <= cmd_cnt_q + 1'b1;
      end
   end

endmodule

// File: rtl/refill_beat_ctr.sv
module refill_beat_ctr #(
   parameter int WORDS = 8,
   parameter int IDX_W = 3
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             beat_valid,
   output logic [IDX_W-1:0] beat_idx,
   output logic             last_beat
);

   logic [IDX_W-1:0] cnt_q;

   assign beat_idx  = cnt_q;
   assign last_beat = beat_valid && (cnt_q == IDX_W'(WORDS - 1));

   always_ff @(posedge clk) begin
      if (rst) begin
         cnt_q <= '0;
      end else if (beat_valid) begin
         cnt_q <= last_beat ? '0 : cnt_q + 1'b1;
      end
   end

   assert_idx_step_R7: assert property (@(posedge clk) disable iff (rst)
      (beat_valid && !last_beat) |=> (beat_idx == $past(beat_idx) + 1'b1));

   assert_idx_wrap_R7: assert property (@(posedge clk) disable iff (rst)
      last_beat |=> (beat_idx == '0));

endmodule

// File: rtl/line_refill_engine.sv
module line_refill_engine
   import refill_pkg::*;
#(
   parameter int ADDR_W      = 32,
   parameter int LINE_BYTES  = 32,
   parameter int CACHE_BYTES = 4096,
   parameter bit BURST_EN    = 1'b1,
   localparam int WORDS      = LINE_BYTES / 4,
   localparam int IDX_W      = index_width(WORDS),
   localparam int BC_W       = $clog2(WORDS) + 1
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              miss_valid,
   input  logic [ADDR_W-1:0] miss_addr,
   output logic              busy,
   output logic              done,
   output logic              rd_req,
   output logic [ADDR_W-1:0] rd_addr,
   output logic [BC_W-1:0]   rd_burstcount,
   input  logic              rd_waitreq,
   input  logic              rd_dvalid,
   input  logic [31:0]       rd_data,
   output logic              line_we,
   output logic [IDX_W-1:0]  line_idx,
   output logic [31:0]       line_wdata
);

   localparam int  OFF_W     = $clog2(LINE_BYTES);
   localparam bit  USE_BURST = BURST_EN && (WORDS > 1);
   localparam int  NUM_LINES = (CACHE_BYTES == 0) ? 0 : CACHE_BYTES / LINE_BYTES;

   // R11: elaboration-time parameter checks
   generate
      if (!(LINE_BYTES == 4 || LINE_BYTES == 16 || LINE_BYTES == 32)) begin : g_bad_line
         $error("line_refill_engine: LINE_BYTES must be 4, 16 or 32");
      end
      if (CACHE_BYTES != 0 &&
          (CACHE_BYTES < 512 || CACHE_BYTES > 65536 ||
           (NUM_LINES & (NUM_LINES - 1)) != 0 ||
           NUM_LINES * LINE_BYTES != CACHE_BYTES)) begin : g_bad_cap
         $error("line_refill_engine: CACHE_BYTES must be 0 or a power of two in 512..65536");
      end
      if (ADDR_W <= OFF_W) begin : g_bad_addr
         $error("line_refill_engine: ADDR_W too small for the line size");
      end
   endgenerate

   refill_state_e     state_q;
   logic [ADDR_W-1:0] base_q;
   logic              done_q;
   logic              accept;
   logic              cmd_done;
   logic              beat_valid;
   logic              last_beat;
   logic              unused_offset;

   assign unused_offset = ^miss_addr[OFF_W-1:0];
   assign accept        = (state_q == RF_IDLE) && miss_valid;
   assign busy          = (state_q != RF_IDLE);
   assign rd_req        = (state_q == RF_CMD);
   assign done          = done_q;
   assign beat_valid    = busy && rd_dvalid;

   always_ff @(posedge clk) begin
      if (rst) begin
         state_q <= RF_IDLE;
         base_q  <= '0;
         done_q  <= 1'b0;
      end else begin
         done_q <= last_beat;
         if (accept) begin
            state_q <= RF_CMD;
            base_q  <= {miss_addr[ADDR_W-1:OFF_W], {OFF_W{1'b0}}};
         end else if (last_beat) begin
            state_q <= RF_IDLE;
         end else if (cmd_done) begin
            state_q <= RF_WAIT;
         end
      end
   end

   refill_cmd_gen #(
      .ADDR_W   (ADDR_W),
      .WORDS    (WORDS),
      .IDX_W    (IDX_W),
      .BC_W     (BC_W),
      .USE_BURST(USE_BURST)
   ) u_cmd (
      .clk          (clk),
      .rst          (rst),
      .start        (accept),
      .active       (rd_req),
      .base_addr    (base_q),
      .rd_waitreq   (rd_waitreq),
      .rd_addr      (rd_addr),
      .rd_burstcount(rd_burstcount),
      .cmd_done     (cmd_done)
   );

   refill_beat_ctr #(
      .WORDS(WORDS),
      .IDX_W(IDX_W)
   ) u_beat (
      .clk       (clk),
      .rst       (rst),
      .beat_valid(beat_valid),
      .beat_idx  (line_idx),
      .last_beat (last_beat)
   );

   assign line_we    = beat_valid;
   assign line_wdata = rd_data;

   assert_cmd_hold_R6: assert property (@(posedge clk) disable iff (rst)
      (rd_req && rd_waitreq) |=> (rd_req && $stable(rd_addr) && $stable(rd_burstcount)));

   assert_first_aligned_R2: assert property (@(posedge clk) disable iff (rst)
      $rose(rd_req) |-> (rd_addr[OFF_W-1:0] == '0));

   assert_done_single_R9: assert property (@(posedge clk) disable iff (rst)
      done |=> !done);

   assert_done_after_last_R9: assert property (@(posedge clk) disable iff (rst)
      done |-> (!busy && $past(line_we) && $past(line_idx) == IDX_W'(WORDS - 1)));

   assert_base_hold_R10: assert property (@(posedge clk) disable iff (rst)
      busy |=> $stable(base_q));

endmodule

// File: tb/tb_line_refill_engine.sv
module tb_refill_mem #(
   parameter int       BC_W  = 4,
   parameter bit [15:0] SEED = 16'hACE1,
   parameter bit       STALL = 1'b1
) (
   input  logic            clk,
   input  logic            rst,
   input  logic            req,
   input  logic [31:0]     addr,
   input  logic [BC_W-1:0] bc,
   output logic            waitreq,
   output logic            dvalid,
   output logic [31:0]     data
);
   logic [15:0] lfsr;
   logic [31:0] pend[$];

   function automatic logic [31:0] memword(input logic [31:0] a);
      return {a[15:0], 16'h0} ^ a ^ 32'h3C5A_0000;
   endfunction

   assign waitreq = STALL && lfsr[1];

   always @(posedge clk) begin
      if (rst) begin
         lfsr   <= SEED;
         dvalid <= 1'b0;
         data   <= '0;
         pend.delete();
      end else begin
         lfsr <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
         if (req && !waitreq) begin
            for (int i = 0; i < int'(bc); i++) pend.push_back(addr + 32'(4 * i));
         end
         if (pend.size() > 0 && (lfsr[3] || lfsr[6])) begin
            dvalid <= 1'b1;
            data   <= memword(pend.pop_front());
         end else begin
            dvalid <= 1'b0;
         end
      end
   end
endmodule

module tb_refill_lane #(
   parameter int        LINE  = 32,
   parameter bit        BURST = 1'b1,
   parameter bit [15:0] SEED  = 16'hACE1
) (
   input logic clk,
   input logic rst
);
   localparam int WORDS = LINE / 4;
   localparam int IDX_W = (WORDS > 1) ? $clog2(WORDS) : 1;
   localparam int BC_W  = $clog2(WORDS) + 1;
   localparam bit UB    = BURST && (WORDS > 1);

   typedef struct { logic [31:0] a; int n; } cmd_t;
   typedef struct { int idx; logic [31:0] d; } wr_t;

   cmd_t cq[$];
   wr_t  wq[$];
   int   n_chk = 0, n_fail = 0, done_cnt = 0, overlap = 0;
   bit   first_cmd = 0, prev_stall = 0, prev_done = 0;
   logic [31:0] hold_a;
   int   hold_n;

   logic            miss_valid = 1'b0;
   logic [31:0]     miss_addr  = '0;
   logic            busy, done, rd_req, rd_waitreq, rd_dvalid, line_we;
   logic [31:0]     rd_addr, rd_data, line_wdata;
   logic [BC_W-1:0] rd_burstcount;
   logic [IDX_W-1:0] line_idx;

   line_refill_engine #(.LINE_BYTES(LINE), .BURST_EN(BURST)) dut (
      .clk(clk), .rst(rst), .miss_valid(miss_valid), .miss_addr(miss_addr),
      .busy(busy), .done(done), .rd_req(rd_req), .rd_addr(rd_addr),
      .rd_burstcount(rd_burstcount), .rd_waitreq(rd_waitreq),
      .rd_dvalid(rd_dvalid), .rd_data(rd_data), .line_we(line_we),
      .line_idx(line_idx), .line_wdata(line_wdata));

   tb_refill_mem #(.BC_W(BC_W), .SEED(SEED), .STALL(1'b1)) mem (
      .clk(clk), .rst(rst), .req(rd_req), .addr(rd_addr), .bc(rd_burstcount),
      .waitreq(rd_waitreq), .dvalid(rd_dvalid), .data(rd_data));

   function automatic logic [31:0] memword(input logic [31:0] a);
      return {a[15:0], 16'h0} ^ a ^ 32'h3C5A_0000;
   endfunction

   task automatic check(input bit ok, input string tag, input logic [31:0] act,
                        input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s (line %0d): actual %0h expected %0h", tag, LINE, act, exp);
      end
   endtask

   task automatic check_idle(input string tag);
      check(!busy && !done && !rd_req && !line_we, tag,
            {28'h0, busy, done, rd_req, line_we}, 32'h0);
   endtask

   task automatic flush();
      cq.delete();
      wq.delete();
      first_cmd = 0;
   endtask

   // driver: pushes expected commands and writes, then pulses the miss
   task automatic start(input logic [31:0] a);
      logic [31:0] base;
      base = a & ~32'(LINE - 1);
      for (int i = 0; i < WORDS; i++) begin
         wr_t w;
         w.idx = i;
         w.d   = memword(base + 32'(4 * i));
         wq.push_back(w);
      end
      if (UB) begin
         cmd_t c;
         c.a = base; c.n = WORDS;
         cq.push_back(c);
      end else begin
         for (int i = 0; i < WORDS; i++) begin
            cmd_t c;
            c.a = base + 32'(4 * i); c.n = 1;
            cq.push_back(c);
         end
      end
      first_cmd  = 1;
      miss_valid = 1'b1;
      miss_addr  = a;
      @(negedge clk);
      miss_valid = 1'b0;
      check(busy, "R9 busy after accept", {31'h0, busy}, 32'h1);
   endtask

   task automatic refill(input logic [31:0] a, input bit poke);
      int d0, guard;
      while (busy) @(negedge clk);
      d0 = done_cnt;
      start(a);
      if (poke) begin
         // R10: requests while busy must be ignored
         for (int k = 0; k < 3; k++) begin
            if (!busy) break;
            miss_valid = 1'b1;
            miss_addr  = a ^ 32'h1000_0040;
            @(negedge clk);
         end
         miss_valid = 1'b0;
      end
      guard = 0;
      while (done_cnt == d0 && guard < 3000) begin
         @(negedge clk);
         guard++;
      end
      check(done_cnt > d0, "R9 refill completes", 32'(done_cnt), 32'(d0 + 1));
      @(negedge clk);
      check(!done && !busy, "R9 done lasts one cycle", {30'h0, done, busy}, 32'h0);
   endtask

   // monitor / scoreboard
   always @(negedge clk) begin
      if (rst) begin
         prev_stall = 0;
         prev_done  = 0;
      end else begin
         if (prev_stall)
            check(rd_req && rd_addr == hold_a && int'(rd_burstcount) == hold_n,
                  "R6 command held under stall", rd_addr, hold_a);
         prev_stall = rd_req && rd_waitreq;
         hold_a     = rd_addr;
         hold_n     = int'(rd_burstcount);
         if (rd_req && !rd_waitreq) begin
            if (cq.size() == 0) begin
               check(0, "R10 unexpected command", rd_addr, 32'h0);
            end else begin
               cmd_t e;
               e = cq.pop_front();
               if (first_cmd)
                  check(rd_addr == e.a, "R2 first address aligned", rd_addr, e.a);
               first_cmd = 0;
               check(rd_addr == e.a, (LINE == 4) ? "R5 addr" : (UB ? "R3 addr" : "R4 addr"),
                     rd_addr, e.a);
               check(int'(rd_burstcount) == e.n,
                     (LINE == 4) ? "R5 count" : (UB ? "R3 count" : "R4 count"),
                     32'(rd_burstcount), 32'(e.n));
            end
         end
         if (line_we) begin
            if (rd_req) overlap++;
            if (wq.size() == 0) begin
               check(0, "R7 unexpected write", line_wdata, 32'h0);
            end else begin
               wr_t w;
               w = wq.pop_front();
               check(int'(line_idx) == w.idx, "R7 index", 32'(line_idx), 32'(w.idx));
               check(line_wdata == w.d, "R7 data", line_wdata, w.d);
            end
         end
         if (done) begin
            done_cnt++;
            check(!busy && wq.size() == 0 && cq.size() == 0, "R9 done at end",
                  32'(wq.size() + cq.size()), 32'h0);
            check(!prev_done, "R9 single pulse", {31'h0, prev_done}, 32'h0);
         end
         prev_done = done;
      end
   end
endmodule

module tb_line_refill_engine;
   logic clk = 1'b0;
   logic rst = 1'b1;
   int   top_chk = 0, top_fail = 0;
   bit   reported = 0;

   always #5 clk = ~clk;

   tb_refill_lane #(.LINE(32), .BURST(1'b1), .SEED(16'hACE1)) l32 (.clk(clk), .rst(rst));
   tb_refill_lane #(.LINE(16), .BURST(1'b0), .SEED(16'h1F35)) l16 (.clk(clk), .rst(rst));
   tb_refill_lane #(.LINE(4),  .BURST(1'b1), .SEED(16'h7B02)) l4  (.clk(clk), .rst(rst));

   task automatic tcheck(input bit ok, input string tag, input int act, input int exp);
      top_chk++;
      if (!ok) begin
         top_fail++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
      end
   endtask

   task automatic report();
      if (!reported) begin
         reported = 1;
         $display("End of test - %0d assertions evaluated, %0d failures",
                  top_chk + l32.n_chk + l16.n_chk + l4.n_chk,
                  top_fail + l32.n_fail + l16.n_fail + l4.n_fail);
      end
   endtask

   initial begin
      repeat (4) @(negedge clk);
      // R1: idle state under reset
      l32.check_idle("R1 reset state");
      l16.check_idle("R1 reset state");
      l4.check_idle("R1 reset state");
      rst = 1'b0;
      @(negedge clk);
      l32.check_idle("R1 after reset");

      // R2 R3: 32-byte bursts, miss at byte 8 fetches from offset 0
      l32.refill(32'h0000_1008, 1'b0);
      l32.refill(32'h0000_203C, 1'b1);
      // R4 R8: single-word reads on 16-byte lines
      l16.refill(32'h0000_0008, 1'b0);
      l16.refill(32'h00AB_CDEF, 1'b1);
      // R5: 4-byte line never bursts
      l4.refill(32'h0000_0106, 1'b0);
      l4.refill(32'hFFFF_FFFD, 1'b1);
      for (int i = 0; i < 10; i++) begin
         l32.refill(32'(i * 32'h74 + 3), i[0]);
         l16.refill(32'(i * 32'h1D3 + 9), i[1]);
         l4.refill(32'(i * 32'h55), i[0]);
      end

      // R12: reset in the middle of a refill
      while (l32.busy) @(negedge clk);
      l32.start(32'h0000_4010);
      repeat (2) @(negedge clk);
      tcheck(l32.busy == 1'b1, "R12 refill in progress", int'(l32.busy), 1);
      rst = 1'b1;
      @(negedge clk);
      l32.flush();
      @(negedge clk);
      l32.check_idle("R12 reset mid-refill");
      rst = 1'b0;
      @(negedge clk);
      l32.check_idle("R12 idle after release");
      l32.refill(32'h0000_5004, 1'b0);

      // R8: data observed while commands were still issuing
      tcheck(l16.overlap > 0, "R8 data overlaps commands", l16.overlap, 1);
      // R11: each legal line size elaborated and completed refills
      tcheck(l4.done_cnt >= 12 && l16.done_cnt >= 12 && l32.done_cnt >= 12,
             "R11 legal geometries run", l4.done_cnt + l16.done_cnt + l32.done_cnt, 36);

      repeat (5) @(negedge clk);
      report();
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      top_chk++;
      top_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      report();
      $finish;
   end
endmodule